// File: doc/BRIEF.md
# Single-Transfer I/O Bus Cycle Master

This block turns I/O read and I/O write requests from an internal command port into single-transfer bus cycles on a 64-bit data bus. Each request is accepted with a valid/ready handshake. The block then drives a one-clock active-low address strobe together with a 29-bit quadword address, eight active-low byte enables and the cycle-type outputs. After that it waits as many clocks as the target needs until an active-low ready input is seen. A write drives its data word until the target accepts it. A read captures the bus data on the edge that samples ready. Completion is reported with a one-clock done pulse that carries the read data.

Ready is sampled only from the second edge after the strobe is asserted, which is the first edge after the strobe is released. As soon as a cycle completes, a new request can launch the next strobe on the following edge, with no idle clock forced in between. The cycle-type outputs always mark the access as I/O data: the memory-select line is low and the data/code line is high.

Top module: `iobus_cycle_master`

## Requirements
- R1: While `rst` is high, `cmdReady` is 0, `busAddrStrobeN` is 1 and `busDataOe` is 0, and a request held on the command port during reset starts no bus cycle, either during reset or after reset is released with `cmdValid` low.
- R2: `busMemNotIo` is always 0 and `busDataNotCode` is always 1.
- R3: A request accepted on an edge (`cmdValid` and `cmdReady` both 1) drives `busAddrStrobeN` low from that edge for exactly one clock. On the same edge it drives `busAddr` = `cmdAddr`, `busByteEnN` = bitwise inverse of `cmdByteEn` (bit i enables byte lane i, data bits 8i+7..8i), and `busWriteNotRead` = `cmdWrite` (1 = write).
- R4: `busAddr`, `busByteEnN` and `busWriteNotRead` stay unchanged from the strobe edge until the cycle completes.
- R5: `busReadyN` is ignored on the edge that releases the strobe. It is sampled on every edge from the next one onward.
- R6: The cycle completes on the first sampling edge where `busReadyN` is 0, after any number of wait states. `cmdReady` is 0 while a cycle is in progress.
- R7: For a write, `busDataOe` is 1 and `busDataOut` holds `cmdWrData` from the edge after the strobe edge up to the completing edge, where `busDataOe` returns to 0.
- R8: For a read, `busDataOe` stays 0, and `rspRdData` presents the value of `busDataIn` sampled on the completing edge.
- R9: After a completing edge `cmdReady` is 1, so a waiting request drives its strobe low on the very next edge.
- R10: `rspDone` is 1 for exactly the one clock that follows each completing edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Request accepted this edge when high with cmdValid |
| cmdWrite | input | 1 | 1 = I/O write, 0 = I/O read |
| cmdAddr | input | 29 | Quadword address |
| cmdByteEn | input | 8 | Active-high byte lane enables |
| cmdWrData | input | 64 | Write data word |
| rspDone | output | 1 | One-clock completion pulse |
| rspRdData | output | 64 | Read data of the last completed read |
| busAddrStrobeN | output | 1 | Active-low address strobe |
| busAddr | output | 29 | Bus quadword address |
| busByteEnN | output | 8 | Active-low byte enables |
| busWriteNotRead | output | 1 | 1 = write cycle |
| busMemNotIo | output | 1 | Memory/I/O select, held low |
| busDataNotCode | output | 1 | Data/code select, held high |
| busReadyN | input | 1 | Active-low ready from the target |
| busDataOut | output | 64 | Write data driven to the bus |
| busDataOe | output | 1 | Data bus output enable |
| busDataIn | input | 64 | Read data from the bus |

## Verification
The bench sweeps both directions against zero to three wait states, with and without a ready pulse placed on the strobe-release edge. This separates early sampling from correct sampling and shows whether the wait count is respected. Each run uses its own address, byte-enable and data pattern, so a stale or swapped field is caught on the strobe clock and on completion. Cycles are chained back to back, which shows the absence of an idle clock. A reset with a pending request shows that requests are blocked during reset.

// File: rtl/iobus_pkg.sv
package iobus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } busState_t;

  typedef struct packed {
    logic loadCmd;
    logic advance;
    logic finish;
  } ctrlStrobes_t;
endpackage

// File: rtl/iobus_ctrl.sv
module iobus_ctrl
  import iobus_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cmdValid,
  input  logic         busReadyN,
  output logic         cmdReady,
  output logic         cycleBusy,
  output ctrlStrobes_t strobes
);
  busState_t state, stateNext;

  always_comb begin
    cmdReady        = (state == ST_IDLE) && !rst;
    strobes.loadCmd = cmdReady && cmdValid;
    strobes.advance = (state == ST_ADDR);
    strobes.finish  = (state == ST_DATA) && !busReadyN;
    cycleBusy       = (state != ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobes.loadCmd) stateNext = ST_ADDR;
      ST_ADDR: stateNext = ST_DATA;
      ST_DATA: if (strobes.finish) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R5: ready only counts once the strobe clock is over
  assert_addr_phase_ignores_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |=> (state == ST_DATA));
endmodule

// File: rtl/iobus_dpath.sv
module iobus_dpath
  import iobus_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 64,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [BE_W-1:0]   cmdByteEn,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busAddrStrobeN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busByteEnN,
  output logic              busWriteNotRead,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdData
);
  logic [BE_W-1:0] laneEnN;

  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    assign laneEnN[lane] = ~cmdByteEn[lane];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busAddrStrobeN  <= 1'b1;
      busAddr         <= '0;
      busByteEnN      <= '1;
      busWriteNotRead <= 1'b0;
      busDataOut      <= '0;
    end else begin
      busAddrStrobeN <= !strobes.loadCmd;
      if (strobes.loadCmd) begin
        busAddr         <= cmdAddr;
        busByteEnN      <= laneEnN;
        busWriteNotRead <= cmdWrite;
        busDataOut      <= cmdWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busDataOe <= 1'b0;
      rspDone   <= 1'b0;
      rspRdData <= '0;
    end else begin
      if (strobes.advance && busWriteNotRead) busDataOe <= 1'b1;
      else if (strobes.finish)                busDataOe <= 1'b0;
      rspDone <= strobes.finish;
      if (strobes.finish && !busWriteNotRead) rspRdData <= busDataIn;
    end
  end

  assert_ads_one_clock_R3: assert property (@(posedge clk) disable iff (rst)
    !busAddrStrobeN |=> busAddrStrobeN);

  assert_oe_only_write_R8: assert property (@(posedge clk) disable iff (rst)
    busDataOe |-> busWriteNotRead);

  assert_wdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busDataOe && $past(busDataOe)) |-> $stable(busDataOut));
endmodule

// File: rtl/iobus_cycle_master.sv
module iobus_cycle_master
  import iobus_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 64,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [BE_W-1:0]   cmdByteEn,
  input  logic [DATA_W-1:0] cmdWrData,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdData,
  output logic              busAddrStrobeN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busByteEnN,
  output logic              busWriteNotRead,
  output logic              busMemNotIo,
  output logic              busDataNotCode,
  input  logic              busReadyN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn
);
  ctrlStrobes_t strobes;
  logic         cycleBusy;

  assign busMemNotIo    = 1'b0;
  assign busDataNotCode = 1'b1;

  iobus_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmdValid  (cmdValid),
    .busReadyN (busReadyN),
    .cmdReady  (cmdReady),
    .cycleBusy (cycleBusy),
    .strobes   (strobes)
  );

  iobus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk             (clk),
    .rst             (rst),
    .strobes         (strobes),
    .cmdWrite        (cmdWrite),
    .cmdAddr         (cmdAddr),
    .cmdByteEn       (cmdByteEn),
    .cmdWrData       (cmdWrData),
    .busDataIn       (busDataIn),
    .busAddrStrobeN  (busAddrStrobeN),
    .busAddr         (busAddr),
    .busByteEnN      (busByteEnN),
    .busWriteNotRead (busWriteNotRead),
    .busDataOut      (busDataOut),
    .busDataOe       (busDataOe),
    .rspDone         (rspDone),
    .rspRdData       (rspRdData)
  );

  assert_reset_blocks_R1: assert property (@(posedge clk)
    rst |-> !cmdReady);

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (cycleBusy && $past(cycleBusy)) |->
      ($stable(busAddr) && $stable(busByteEnN) && $stable(busWriteNotRead)));

  assert_no_instant_done_R5: assert property (@(posedge clk) disable iff (rst)
    !busAddrStrobeN |=> !rspDone);

  assert_busy_blocks_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    cycleBusy |-> !cmdReady);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rspDone |=> !rspDone);
endmodule

// File: tb/iobus_cycle_master_test.sv
`timescale 1ns/1ps
module iobus_cycle_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic        cmdWrite = 1'b0;
  logic [28:0] cmdAddr = '0;
  logic [7:0]  cmdByteEn = '0;
  logic [63:0] cmdWrData = '0;
  logic        rspDone;
  logic [63:0] rspRdData;
  logic        busAddrStrobeN;
  logic [28:0] busAddr;
  logic [7:0]  busByteEnN;
  logic        busWriteNotRead;
  logic        busMemNotIo;
  logic        busDataNotCode;
  logic        busReadyN = 1'b1;
  logic [63:0] busDataOut;
  logic        busDataOe;
  logic [63:0] busDataIn = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  iobus_cycle_master uut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkType();
    check(busMemNotIo == 1'b0, "R2 memNotIo", 64'(busMemNotIo), 64'd0);
    check(busDataNotCode == 1'b1, "R2 dataNotCode", 64'(busDataNotCode), 64'd1);
  endtask

  // Runs one cycle starting at a negative edge; returns at the negative edge after completion.
  task automatic runCycle(input bit wr, input logic [28:0] addr, input logic [7:0] be,
                          input logic [63:0] wdata, input logic [63:0] rdata,
                          input int waits, input bit earlyReady);
    cmdValid  = 1'b1;
    cmdWrite  = wr;
    cmdAddr   = addr;
    cmdByteEn = be;
    cmdWrData = wdata;
    check(cmdReady == 1'b1, "R9 ready before launch", 64'(cmdReady), 64'd1);
    @(negedge clk);
    check(busAddrStrobeN == 1'b0, "R3 strobe low", 64'(busAddrStrobeN), 64'd0);
    check(busAddr == addr, "R3 address", 64'(busAddr), 64'(addr));
    check(busByteEnN == ~be, "R3 byte enables", 64'(busByteEnN), 64'(~be));
    check(busWriteNotRead == wr, "R3 direction", 64'(busWriteNotRead), 64'(wr));
    check(cmdReady == 1'b0, "R6 busy blocks", 64'(cmdReady), 64'd0);
    checkType();
    cmdValid  = 1'b0;
    cmdAddr   = ~addr;
    cmdByteEn = ~be;
    cmdWrData = ~wdata;
    busReadyN = earlyReady ? 1'b0 : 1'b1;
    busDataIn = earlyReady ? ~rdata : rdata;
    @(negedge clk);
    check(busAddrStrobeN == 1'b1, "R3 strobe one clock", 64'(busAddrStrobeN), 64'd1);
    check(rspDone == 1'b0, "R5 early ready ignored", 64'(rspDone), 64'd0);
    check(busDataOe == wr, "R7 oe after strobe", 64'(busDataOe), 64'(wr));
    if (wr) check(busDataOut == wdata, "R7 write data", busDataOut, wdata);
    busReadyN = 1'b1;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      check(rspDone == 1'b0, "R6 wait state", 64'(rspDone), 64'd0);
      check(busAddr == addr && busByteEnN == ~be && busWriteNotRead == wr,
            "R4 fields stable", 64'(busAddr), 64'(addr));
      check(busDataOe == wr, "R8 oe level in wait", 64'(busDataOe), 64'(wr));
      if (wr) check(busDataOut == wdata, "R7 data held", busDataOut, wdata);
    end
    busReadyN = 1'b0;
    busDataIn = rdata;
    @(negedge clk);
    busReadyN = 1'b1;
    busDataIn = ~rdata;
    check(rspDone == 1'b1, "R10 done pulse", 64'(rspDone), 64'd1);
    check(busDataOe == 1'b0, "R7 oe released", 64'(busDataOe), 64'd0);
    if (!wr) check(rspRdData == rdata, "R8 read data", rspRdData, rdata);
    check(cmdReady == 1'b1, "R9 ready after completion", 64'(cmdReady), 64'd1);
    checkType();
  endtask

  initial begin
    cmdValid  = 1'b1;
    cmdWrite  = 1'b1;
    cmdAddr   = 29'h1234567;
    cmdByteEn = 8'hFF;
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b0, "R1 ready in reset", 64'(cmdReady), 64'd0);
    check(busAddrStrobeN == 1'b1, "R1 strobe in reset", 64'(busAddrStrobeN), 64'd1);
    check(busDataOe == 1'b0, "R1 oe in reset", 64'(busDataOe), 64'd0);
    cmdValid = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(busAddrStrobeN == 1'b1, "R1 no cycle after reset", 64'(busAddrStrobeN), 64'd1);
    check(rspDone == 1'b0, "R1 no done after reset", 64'(rspDone), 64'd0);
    checkType();

    for (int k = 0; k < 16; k++) begin
      bit wr = k[0];
      bit early = k[1];
      int waits = k >> 2;
      logic [28:0] addr = 29'h0F00000 + 29'(k * 29'h11111);
      logic [7:0] be = (k % 3 == 0) ? 8'hFF : 8'(8'h01 << (k % 8));
      logic [63:0] wdata = {32'hC0DE0000 + 32'(k), 32'hFFFF0000 ^ 32'(k * 7)};
      logic [63:0] rdata = {32'h5A5A0000 + 32'(k * 3), 32'h00AB0000 + 32'(k)};
      runCycle(wr, addr, be, wdata, rdata, waits, early);
    end
    @(negedge clk);
    check(rspDone == 1'b0, "R10 done single clock", 64'(rspDone), 64'd0);
    check(busAddrStrobeN == 1'b1, "R6 idle after last", 64'(busAddrStrobeN), 64'd1);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule